// File: doc/BRIEF.md
# Transmit Jabber Watchdog

This block guards the data transmitter of a twisted-pair line interface against a station that never stops sending. It watches a single transmit-activity level coming from the attachment-unit side. Each transmission starts a timer, and the end of each transmission clears it. If one transmission outlasts the activation interval, the block enters a latched jabber condition. In that condition it withdraws the data transmit enable, asks the collision oscillator to run, and pulls its active-low jabber status low.

The latch opens only after the transmit input has stayed idle for one unbroken recovery interval. Any activity during that interval restarts the measurement from zero. The enable output gates only the data path. Link-pulse generation elsewhere is not affected by it. A configuration level turns the watchdog off entirely: while it is high, transmission is unlimited and no collision request comes from this block.

Both intervals count whole milliseconds. A prescaler derives the millisecond step from the system clock, and all three counts are parameters, so a simulation can run with short intervals. The FSM states are IDLE (no activity), SEND (activity, activation timer running), JABBED (activity while latched) and QUIET (latched, recovery timer running). The transitions are: START (IDLE to SEND), FINISH (SEND to IDLE), TRIP (SEND to JABBED), HUSH (JABBED to QUIET), RESUME (QUIET to JABBED), RELEASE (QUIET to IDLE), and BYPASS (any state to IDLE while disabled).

Top module: `txjab_guard`

## Requirements
- R1: After reset, tx_enable is 1, jab_active_n is 1 and col_request is 0, and both timers are cleared.
- R2: A transmission trips only if tx_active is sampled high on JAB_MS*TICKS_PER_MS+2 consecutive rising edges. One low sample clears the timer, so a later burst measures afresh. A burst that ends on the edge where the timer reaches its limit does not trip.
- R3: When a burst reaches JAB_MS*TICKS_PER_MS+2 consecutive high samples, the outputs show jabber right after the last of those edges.
- R4: In jabber, tx_enable is 0, col_request is 1 and jab_active_n is 0, all three in the same cycle. Outside jabber they are 1, 0 and 1.
- R5: While latched, continuing activity keeps the jabber outputs unchanged for any length of time.
- R6: A latched block returns to normal right after tx_active has been sampled low on UNJAB_MS*TICKS_PER_MS+2 consecutive edges, and not before.
- R7: A high sample on tx_active during the recovery interval restarts it from zero. This includes a high sample on the edge where recovery would otherwise complete.
- R8: While jab_disable is sampled high, the block goes to or stays in normal output (tx_enable 1, col_request 0, jab_active_n 1) from the next edge on. When jab_disable falls during ongoing activity, a fresh activation interval starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_active | input | 1 | Transmit activity level from the attachment-unit side |
| jab_disable | input | 1 | 1 turns the watchdog off |
| tx_enable | output | 1 | Data transmit enable toward the line driver |
| jab_active_n | output | 1 | Jabber status, low while latched |
| col_request | output | 1 | Request to run the collision oscillator |

## Verification
The most delicate coincidences arise when the timer reaches its limit on the same edge where the input changes. An activation limit can meet the end of a burst, and the recovery limit can meet a new burst. The directed cases place the input edge exactly one sample before and exactly on the limiting edge, and compare the outputs against fixed expected values: no trip in the first case, continued latching in the second. A random phase then mixes burst lengths around both limits with occasional disabling. It compares all three outputs every cycle against a model of the requirements kept inside the bench.

// File: rtl/txjab_pkg.sv
package txjab_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SEND   = 2'd1,
        ST_JABBED = 2'd2,
        ST_QUIET  = 2'd3
    } jab_state_t;

    typedef enum logic {
        LIM_ACTIVATE = 1'b0,
        LIM_RECOVER  = 1'b1
    } limit_sel_t;

endpackage

// File: rtl/txjab_ms_prescaler.sv
module txjab_ms_prescaler #(
    parameter int TICKS_PER_MS = 20000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic ms_tick
);

    generate
        if (TICKS_PER_MS <= 1) begin : g_direct
            assign ms_tick = run;
        end else begin : g_count
            localparam int PW = $clog2(TICKS_PER_MS);
            localparam logic [PW-1:0] LAST = PW'(TICKS_PER_MS - 1);
            logic [PW-1:0] cnt_q;

            assign ms_tick = run && (cnt_q == LAST);

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cnt_q <= '0;
                end else if (!run || ms_tick) begin
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/txjab_interval_timer.sv
module txjab_interval_timer
    import txjab_pkg::*;
#(
    parameter int TICKS_PER_MS = 20000,
    parameter int JAB_MS       = 20,
    parameter int UNJAB_MS     = 500
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  limit_sel_t sel,
    output logic       done
);

    localparam int MAX_MS = (UNJAB_MS > JAB_MS) ? UNJAB_MS : JAB_MS;
    localparam int MW     = $clog2(MAX_MS + 1);
    localparam logic [MW-1:0] LIM_A = MW'(JAB_MS);
    localparam logic [MW-1:0] LIM_R = MW'(UNJAB_MS);

    logic [MW-1:0] ms_q;
    logic [MW-1:0] limit;
    logic          tick;
    logic          reached;

    assign limit   = (sel == LIM_RECOVER) ? LIM_R : LIM_A;
    assign reached = (ms_q == limit);
    assign done    = run && reached;

    txjab_ms_prescaler #(
        .TICKS_PER_MS(TICKS_PER_MS)
    ) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run && !reached),
        .ms_tick(tick)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ms_q <= '0;
        end else if (!run) begin
            ms_q <= '0;
        end else if (tick) begin
            ms_q <= ms_q + 1'b1;
        end
    end

endmodule

// File: rtl/txjab_fsm.sv
module txjab_fsm
    import txjab_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tx_active,
    input  logic       jab_disable,
    input  logic       tmr_done,
    output logic       tmr_run,
    output limit_sel_t tmr_sel,
    output logic       latched
);

    jab_state_t state_q;
    jab_state_t state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (tx_active && !jab_disable) state_d = ST_SEND;        // START
            end
            ST_SEND: begin
                if (jab_disable || !tx_active) state_d = ST_IDLE;        // BYPASS / FINISH
                else if (tmr_done)             state_d = ST_JABBED;      // TRIP
            end
            ST_JABBED: begin
                if (jab_disable)     state_d = ST_IDLE;                  // BYPASS
                else if (!tx_active) state_d = ST_QUIET;                 // HUSH
            end
            ST_QUIET: begin
                if (jab_disable)    state_d = ST_IDLE;                   // BYPASS
                else if (tx_active) state_d = ST_JABBED;                 // RESUME
                else if (tmr_done)  state_d = ST_IDLE;                   // RELEASE
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        tmr_run = 1'b0;
        tmr_sel = LIM_ACTIVATE;
        latched = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_SEND:   tmr_run = 1'b1;
            ST_JABBED: latched = 1'b1;
            ST_QUIET: begin
                tmr_run = 1'b1;
                tmr_sel = LIM_RECOVER;
                latched = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/txjab_guard.sv
module txjab_guard
    import txjab_pkg::*;
#(
    parameter int TICKS_PER_MS = 20000,
    parameter int JAB_MS       = 20,
    parameter int UNJAB_MS     = 500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_active,
    input  logic jab_disable,
    output logic tx_enable,
    output logic jab_active_n,
    output logic col_request
);

    logic       tmr_run;
    logic       tmr_done;
    logic       latched;
    limit_sel_t tmr_sel;

    txjab_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .tx_active  (tx_active),
        .jab_disable(jab_disable),
        .tmr_done   (tmr_done),
        .tmr_run    (tmr_run),
        .tmr_sel    (tmr_sel),
        .latched    (latched)
    );

    txjab_interval_timer #(
        .TICKS_PER_MS(TICKS_PER_MS),
        .JAB_MS      (JAB_MS),
        .UNJAB_MS    (UNJAB_MS)
    ) u_tmr (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (tmr_run),
        .sel  (tmr_sel),
        .done (tmr_done)
    );

    assign tx_enable    = !latched;
    assign jab_active_n = !latched;
    assign col_request  = latched;

endmodule

// File: rtl/txjab_guard_chk.sv
module txjab_guard_chk #(
    parameter int TICKS_PER_MS = 20000,
    parameter int JAB_MS       = 20,
    parameter int UNJAB_MS     = 500
) (
    input logic clk,
    input logic rst_n,
    input logic tx_active,
    input logic jab_disable,
    input logic tx_enable,
    input logic jab_active_n,
    input logic col_request
);

    localparam int unsigned ACT_CYC = JAB_MS * TICKS_PER_MS;
    localparam int unsigned REC_CYC = UNJAB_MS * TICKS_PER_MS;
    localparam logic [31:0] SAT     = 32'hFFFF_FFF0;

    logic [31:0] busy_run;
    logic [31:0] idle_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_run <= '0;
            idle_run <= '0;
        end else begin
            busy_run <= (!tx_active || jab_disable) ? '0 :
                        ((busy_run < SAT) ? busy_run + 1 : busy_run);
            idle_run <= (tx_active || jab_disable) ? '0 :
                        ((idle_run < SAT) ? idle_run + 1 : idle_run);
        end
    end

    // R4: the three outputs always agree on the latched condition
    assert_outputs_agree_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_enable == jab_active_n) && (col_request == !tx_enable));

    // R3: tripping needs the full activation run of high samples
    assert_trip_after_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_enable) |-> (busy_run >= ACT_CYC + 2));

    // R5: ongoing activity keeps the latch closed
    assert_hold_while_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_enable && tx_active && !jab_disable) |=> !tx_enable);

    // R6 and R7: release needs an unbroken recovery run of idle samples
    assert_release_after_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(tx_enable) && !$past(jab_disable)) |-> (idle_run >= REC_CYC + 2));

    // R8: disabling always yields normal outputs on the next cycle
    assert_disable_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        jab_disable |=> (tx_enable && !col_request && jab_active_n));

endmodule

bind txjab_guard txjab_guard_chk #(
    .TICKS_PER_MS(TICKS_PER_MS),
    .JAB_MS      (JAB_MS),
    .UNJAB_MS    (UNJAB_MS)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tx_active   (tx_active),
    .jab_disable (jab_disable),
    .tx_enable   (tx_enable),
    .jab_active_n(jab_active_n),
    .col_request (col_request)
);

// File: tb/txjab_guard_tb_top.sv
module txjab_guard_tb_top;

    localparam int TPM   = 4;
    localparam int JMS   = 5;
    localparam int UMS   = 8;
    localparam int LIM_A = JMS * TPM;   // 20
    localparam int LIM_R = UMS * TPM;   // 32

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_active = 1'b0;
    logic jab_disable = 1'b0;
    logic tx_enable;
    logic jab_active_n;
    logic col_request;

    int checks = 0;
    int errors = 0;
    bit model_on = 1'b0;
    bit done_flag = 1'b0;

    // requirement-level model: 0 normal-idle, 1 sending, 2 latched-busy, 3 latched-quiet
    int m_st = 0;
    int m_cnt = 0;

    always #10 clk = ~clk;

    txjab_guard #(
        .TICKS_PER_MS(TPM),
        .JAB_MS      (JMS),
        .UNJAB_MS    (UMS)
    ) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .tx_active   (tx_active),
        .jab_disable (jab_disable),
        .tx_enable   (tx_enable),
        .jab_active_n(jab_active_n),
        .col_request (col_request)
    );

    function automatic int next_state(int st, int cnt, bit a, bit d, output int ncnt);
        ncnt = cnt;
        if (d) begin
            ncnt = 0;
            return 0;
        end
        case (st)
            0: begin ncnt = 0; return a ? 1 : 0; end
            1: begin
                if (!a) begin ncnt = 0; return 0; end
                if (cnt == LIM_A) begin ncnt = 0; return 2; end
                ncnt = cnt + 1;
                return 1;
            end
            2: begin ncnt = 0; return a ? 2 : 3; end
            default: begin
                if (a) begin ncnt = 0; return 2; end
                if (cnt == LIM_R) begin ncnt = 0; return 0; end
                ncnt = cnt + 1;
                return 3;
            end
        endcase
    endfunction

    function automatic bit model_latched(int st);
        return (st == 2) || (st == 3);
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st  = 0;
            m_cnt = 0;
        end else begin
            int nc;
            m_st  = next_state(m_st, m_cnt, tx_active, jab_disable, nc);
            m_cnt = nc;
        end
    end

    task automatic check_bit(string tag, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (model_on && rst_n) begin
            bit lat;
            lat = model_latched(m_st);
            check_bit("R4 model tx_enable", tx_enable, !lat);
            check_bit("R4 model col_request", col_request, lat);
            check_bit("R4 model jab_active_n", jab_active_n, !lat);
        end
    end

    task automatic hold(bit a, bit d, int n);
        tx_active   = a;
        jab_disable = d;
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_state(string tag, bit latched_exp);
        check_bit(tag, tx_enable, !latched_exp);
        check_bit(tag, col_request, latched_exp);
        check_bit(tag, jab_active_n, !latched_exp);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            checks++;
            errors++;
            $display("FAIL watchdog all requirements actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        expect_state("R1 reset held", 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        expect_state("R1 after reset", 1'b0);
        model_on = 1'b1;

        // R2: two bursts just under the limit with a one-sample gap
        hold(1, 0, LIM_A + 1);
        hold(0, 0, 1);
        hold(1, 0, LIM_A + 1);
        expect_state("R2 timer cleared between bursts", 1'b0);
        hold(0, 0, 5);
        expect_state("R2 burst ended on limit edge", 1'b0);

        // R3: exact trip point
        hold(1, 0, LIM_A + 1);
        expect_state("R3 one sample before trip", 1'b0);
        hold(1, 0, 1);
        expect_state("R3 R4 tripped", 1'b1);

        // R5: long activity stays latched
        hold(1, 0, 60);
        expect_state("R5 latched while busy", 1'b1);

        // R6: recovery boundary
        hold(0, 0, LIM_R + 1);
        expect_state("R6 one sample before release", 1'b1);
        hold(0, 0, 1);
        expect_state("R6 released", 1'b0);

        // R7: activity inside recovery restarts it
        hold(1, 0, LIM_A + 2);
        expect_state("R7 re-tripped", 1'b1);
        hold(0, 0, 20);
        hold(1, 0, 1);
        hold(0, 0, LIM_R + 1);
        expect_state("R7 restarted interval not yet done", 1'b1);
        hold(1, 0, 1);
        expect_state("R7 activity on final recovery edge", 1'b1);
        hold(0, 0, LIM_R + 2);
        expect_state("R7 released after fresh interval", 1'b0);

        // R8: disable clears the latch and suppresses tripping
        hold(1, 0, LIM_A + 2);
        expect_state("R8 tripped before disable", 1'b1);
        hold(1, 1, 1);
        expect_state("R8 disable clears latch", 1'b0);
        hold(1, 1, 100);
        expect_state("R8 no trip while disabled", 1'b0);
        hold(1, 0, LIM_A + 1);
        expect_state("R8 fresh interval after enable", 1'b0);
        hold(1, 0, 1);
        expect_state("R8 trips after fresh interval", 1'b1);
        hold(0, 1, 3);
        hold(0, 0, 3);

        // random phase: bursts near both limits, occasional disable
        for (int i = 0; i < 120; i++) begin
            int blen;
            int glen;
            bit dis;
            blen = 1 + int'($urandom_range(0, LIM_A + 12));
            glen = 1 + int'($urandom_range(0, LIM_R + 10));
            dis  = ($urandom_range(0, 9) == 0);
            hold(1, dis, blen);
            hold(0, 1'b0, glen);
        end

        done_flag = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule